// File: doc/BRIEF.md
# Double-Buffered PWM Counter with Load Modes

This block is one PWM channel. A counter runs either as a plain up-counter that wraps, or as an up-down counter for center-aligned waveforms. Software writes a period value and a compare value through a small write port. Each value goes into a shadow register first. It is copied into an active register at a point chosen by the load mode: at once on the write, at the end of the period, or at the center of an up-down period. The output is high while the count is below the active compare value. Two single-cycle strobes mark the end point and the center point of each period.

A debug-acknowledge input has two separate effects, each selected by its own control bit. One bit freezes the counter while debug is acknowledged. The other bit chooses whether the pin keeps driving or is released to high impedance through a separate output-enable signal.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset the period, compare and control registers are all 0. With debug not acknowledged, `pwm_out` is 0 and `pwm_oe` is 1.
- R2: With control bit 0 (count mode) at 0, the counter steps 0, 1, …, P and then returns to 0, where P is the active period. `end_pulse` is 1 in the cycle where the count equals P, and `center_pulse` stays 0.
- R3: With control bit 0 at 1, the counter rises from 0 to P and falls back to 0. `center_pulse` is 1 in the cycle at the top and `end_pulse` is 1 in the cycle at the bottom. The first rise after leaving up-count mode sets neither strobe at count 0.
- R4: With control bit 1 (immediate load) at 0, a period write changes only the shadow. The active period takes the shadow value at the clock edge that ends a cycle with `end_pulse` high.
- R5: With immediate load off, and either up-count mode or control bit 2 (center load) at 0, the active compare takes its shadow value at the edge that ends an `end_pulse` cycle.
- R6: In up-down mode with center load on and immediate load off, the active compare loads at the edge that ends a `center_pulse` cycle. The period still loads only on `end_pulse`.
- R7: With immediate load on, a period or compare write takes effect in the active register at the same edge as the shadow. The strobes cause no loads, and center load has no effect.
- R8: `pwm_out` is 1 exactly when count < active compare. A compare of 0 gives a constant 0, and a compare above the period gives a constant 1.
- R9: With control bit 3 (debug halt) at 1 and `dbg_ack` high, the counter holds its value and both strobes stay 0. It resumes from the held value when `dbg_ack` falls.
- R10: `pwm_oe` is 0 while `dbg_ack` is high and control bit 4 (keep driving) is 0. Otherwise `pwm_oe` is 1.
- R11: `wr_sel` selects the target of a write: 0 period, 1 compare, 2 control (the low 5 bits of `wr_data`). A write with `wr_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | CNT_W | Write value |
| dbg_ack | input | 1 | Debug mode acknowledged |
| pwm_out | output | 1 | PWM waveform |
| pwm_oe | output | 1 | Pin output enable (0 = high impedance) |
| end_pulse | output | 1 | Period end point strobe |
| center_pulse | output | 1 | Period center point strobe |

## Verification
The bench targets five corner cases.
- **Writes in the middle of a period in buffered mode.** A design that loads early makes the waveform change before the wrap.
- **Center-load compare updates.** A design that ignores center load moves the duty change half a period late.
- **Immediate writes while center load is set.** A design that lets center load win delays the update.
- **Compare values of 0 and above the period.** An off-by-one comparison shows a stray high or low cycle.
- **Debug acknowledge.** A design that keeps counting, keeps pulsing, or gets the output-enable polarity wrong diverges on the cycle debug is entered.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   typedef enum logic [1:0] {
      SEL_PERIOD  = 2'd0,
      SEL_COMPARE = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_NONE    = 2'd3
   } wr_sel_e;

   // control word, bit 0 in the lowest position
   typedef struct packed {
      logic keep_drive;   // bit 4
      logic dbg_halt;     // bit 3
      logic center_ld;    // bit 2
      logic imm_ld;       // bit 1
      logic updown;       // bit 0
   } ctrl_t;

   localparam int CTRL_W  = 5;
   localparam int N_SLOTS = 2;
   localparam int SLOT_PER = 0;
   localparam int SLOT_CMP = 1;

endpackage

// File: rtl/pwm_dbuf_slot.sv
module pwm_dbuf_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic         imm,
   input  logic         evt_load,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] active_o
);

   logic [W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow   <= '0;
         active_o <= '0;
      end else begin
         if (!imm && evt_load)
            active_o <= shadow;
         if (wr_hit) begin
            shadow <= wr_data;
            if (imm)
               active_o <= wr_data;
         end
      end
   end

   // buffered transfer on the selected event (R4, R5, R6)
   assert_evt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm && evt_load) |=> (active_o == $past(shadow)));

   assert_imm_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (imm && wr_hit) |=> (active_o == $past(wr_data)));

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         updown,
   input  logic         halt,
   input  logic [W-1:0] per_act,
   output logic [W-1:0] cnt_o,
   output logic         end_o,
   output logic         center_o
);

   localparam logic [W-1:0] ONE = W'(1);

   logic dir_up;
   logic at_top, at_bottom, end_raw, center_raw;

   always_comb begin
      at_top     = dir_up && (cnt_o >= per_act);
      at_bottom  = !dir_up && (cnt_o == '0);
      end_raw    = updown ? at_bottom : (cnt_o >= per_act);
      center_raw = updown && at_top;
      end_o      = end_raw && !halt;
      center_o   = center_raw && !halt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         dir_up <= 1'b1;
      end else if (!halt) begin
         if (!updown) begin
            dir_up <= 1'b1;
            cnt_o  <= end_raw ? '0 : cnt_o + ONE;
         end else if (at_top) begin
            dir_up <= 1'b0;
            cnt_o  <= (cnt_o == '0) ? '0 : cnt_o - ONE;
         end else if (at_bottom) begin
            dir_up <= 1'b1;
            cnt_o  <= (per_act == '0) ? '0 : ONE;
         end else begin
            cnt_o <= dir_up ? cnt_o + ONE : cnt_o - ONE;
         end
      end
   end

   assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (cnt_o == $past(cnt_o)));

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!updown && end_o) |=> (cnt_o == '0));

   assert_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (updown && center_o && (cnt_o != '0)) |=> (cnt_o == $past(cnt_o) - ONE));

endmodule

// File: rtl/pwm_dbuf_outgen.sv
module pwm_dbuf_outgen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp_act,
   input  logic [W-1:0] per_act,
   input  logic         dbg_ack,
   input  logic         keep_drive,
   output logic         pwm_out,
   output logic         pwm_oe
);

   always_comb begin
      pwm_out = (cnt < cmp_act);
      pwm_oe  = keep_drive || !dbg_ack;
   end

   // compare above the period keeps the output high (R8)
   assert_cmp_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmp_act > per_act) && (cnt <= per_act)) |-> pwm_out);

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
   import pwm_dbuf_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             dbg_ack,
   output logic             pwm_out,
   output logic             pwm_oe,
   output logic             end_pulse,
   output logic             center_pulse
);

   generate
      if (CNT_W < CTRL_W) begin : g_width_bad
         initial $fatal(1, "pwm_dbuf_top: CNT_W must be at least %0d", CTRL_W);
      end
   endgenerate

   ctrl_t            ctrl;
   wr_sel_e          sel;
   logic             halt;
   logic [CNT_W-1:0] cnt;
   logic [N_SLOTS-1:0]   slot_hit;
   logic [N_SLOTS-1:0]   slot_evt;
   logic [CNT_W-1:0]     slot_act [N_SLOTS];

   assign sel  = wr_sel_e'(wr_sel);
   assign halt = ctrl.dbg_halt && dbg_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (wr_en && sel == SEL_CTRL)
         ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   always_comb begin
      slot_hit[SLOT_PER] = wr_en && (sel == SEL_PERIOD);
      slot_hit[SLOT_CMP] = wr_en && (sel == SEL_COMPARE);
      slot_evt[SLOT_PER] = end_pulse;
      slot_evt[SLOT_CMP] = (ctrl.updown && ctrl.center_ld) ? center_pulse : end_pulse;
   end

   generate
      for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
         pwm_dbuf_slot #(.W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (slot_hit[i]),
            .imm      (ctrl.imm_ld),
            .evt_load (slot_evt[i]),
            .wr_data  (wr_data),
            .active_o (slot_act[i])
         );
      end
   endgenerate

   pwm_dbuf_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .updown   (ctrl.updown),
      .halt     (halt),
      .per_act  (slot_act[SLOT_PER]),
      .cnt_o    (cnt),
      .end_o    (end_pulse),
      .center_o (center_pulse)
   );

   pwm_dbuf_outgen #(.W(CNT_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .cmp_act    (slot_act[SLOT_CMP]),
      .per_act    (slot_act[SLOT_PER]),
      .dbg_ack    (dbg_ack),
      .keep_drive (ctrl.keep_drive),
      .pwm_out    (pwm_out),
      .pwm_oe     (pwm_oe)
   );

   // a write to the unused select leaves the control word alone (R11)
   assert_sel_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_NONE) |=> (ctrl == $past(ctrl)));

endmodule

// File: tb/tb_pwm_dbuf_top.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         dbg_ack = 1'b0;
   logic         pwm_out, pwm_oe, end_pulse, center_pulse;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   pwm_dbuf_top #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .dbg_ack(dbg_ack), .pwm_out(pwm_out),
      .pwm_oe(pwm_oe), .end_pulse(end_pulse), .center_pulse(center_pulse)
   );

   // behavioural reference state
   int m_cnt = 0, m_up = 1, m_pa = 0, m_ca = 0, m_ps = 0, m_cs = 0;
   int m_ctrl = 0;

   function automatic bit m_halt();
      return m_ctrl[3] && dbg_ack;
   endfunction
   function automatic bit m_end_raw();
      if (m_ctrl[0]) return (!m_up && m_cnt == 0);
      return (m_cnt >= m_pa);
   endfunction
   function automatic bit m_cen_raw();
      return m_ctrl[0] && m_up && (m_cnt >= m_pa);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_up = 1; m_pa = 0; m_ca = 0; m_ps = 0; m_cs = 0; m_ctrl = 0;
      end else begin
         bit h, ep, cp;
         int n_cnt, n_up, n_pa, n_ca, n_ps, n_cs, n_ctrl;
         h  = m_halt();
         ep = m_end_raw() && !h;
         cp = m_cen_raw() && !h;
         n_cnt = m_cnt; n_up = m_up;
         if (!h) begin
            if (!m_ctrl[0]) begin
               n_up = 1; n_cnt = m_end_raw() ? 0 : m_cnt + 1;
            end else if (m_up && m_cnt >= m_pa) begin
               n_up = 0; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
            end else if (!m_up && m_cnt == 0) begin
               n_up = 1; n_cnt = (m_pa == 0) ? 0 : 1;
            end else begin
               n_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
            end
         end
         n_pa = m_pa; n_ca = m_ca; n_ps = m_ps; n_cs = m_cs; n_ctrl = m_ctrl;
         if (!m_ctrl[1]) begin
            if (ep) n_pa = m_ps;
            if ((m_ctrl[0] && m_ctrl[2]) ? cp : ep) n_ca = m_cs;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: begin n_ps = wr_data; if (m_ctrl[1]) n_pa = wr_data; end
               2'd1: begin n_cs = wr_data; if (m_ctrl[1]) n_ca = wr_data; end
               2'd2: n_ctrl = wr_data & 8'h1f;
               default: ;
            endcase
         end
         m_cnt = n_cnt; m_up = n_up; m_pa = n_pa; m_ca = n_ca;
         m_ps = n_ps; m_cs = n_cs; m_ctrl = n_ctrl;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the edges
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(tag, "pwm_out", pwm_out, (m_cnt < m_ca));
         check(tag, "pwm_oe", pwm_oe, (m_ctrl[4] || !dbg_ack));
         check(tag, "end_pulse", end_pulse, m_end_raw() && !m_halt());
         check(tag, "center_pulse", center_pulse, m_cen_raw() && !m_halt());
      end
   end

   task automatic wr(input logic [1:0] s, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #2;
      check("R1", "pwm_out in reset", pwm_out, 0);
      check("R1", "pwm_oe in reset", pwm_oe, 1);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1"; run(3);
      tag = "R11"; wr(2'd0, 5); wr(2'd1, 3); run(4);
      tag = "R2"; run(20);
      tag = "R4"; wr(2'd0, 7); run(2); wr(2'd0, 4); run(15);
      tag = "R5"; wr(2'd1, 2); run(12);
      tag = "R3"; wr(2'd2, 1); wr(2'd0, 6); run(30);
      tag = "R6"; wr(2'd2, 5); run(3); wr(2'd1, 4); run(14); wr(2'd1, 1); run(20);
      tag = "R7"; wr(2'd2, 7); run(3); wr(2'd1, 5); run(3); wr(2'd0, 9); run(25);
      tag = "R8"; wr(2'd1, 0); run(25); wr(2'd1, 200); run(25); wr(2'd2, 0); run(15);
      tag = "R9"; wr(2'd2, 8); wr(2'd1, 4); run(5);
      dbg_ack = 1'b1; run(10); dbg_ack = 1'b0; run(15);
      tag = "R10"; wr(2'd2, 0); dbg_ack = 1'b1; run(6); dbg_ack = 1'b0; run(3);
      wr(2'd2, 16); dbg_ack = 1'b1; run(6); dbg_ack = 1'b0; run(3);
      tag = "R11"; wr(2'd3, 31); run(12); wr(2'd3, 1); run(12);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule